// File: doc/BRIEF.md
# UDP Receive Header Parser

This block sits directly above an IPv4 receive layer. The layer below hands it one byte per cycle with valid and last strobes, a frame start flag, and the decoded IP header fields: the protocol number and the source address. When the protocol is UDP, the parser removes the eight-byte UDP header from the front of the byte stream. It presents the source port, destination port, payload length and source IP address on dedicated header outputs. It then forwards the remaining bytes as the payload stream, one cycle behind the input.

Frames that carry any other protocol pass through the parser with no effect. Frames that end before the UDP header is complete are also discarded. A one-cycle start pulse marks the first payload byte of each accepted datagram. The header outputs stay steady while that datagram's payload is delivered. After each frame, the payload outputs return to zero, so a new frame can begin in the very next cycle.

Top module: `udp_hdr_rx`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `udp_sof_o`, `hdr_ok_o`, `pay_vld_o` and `pay_last_o` are 0, and `pay_byte_o`, both port outputs, `pay_len_o` and `src_ip_o` are all zero.
- R2: A frame whose protocol number is not 0x11 never raises `hdr_ok_o`, `udp_sof_o`, `pay_vld_o` or `pay_last_o`. The port, length and source-address outputs keep the values they held before that frame.
- R3: The first eight accepted bytes of a UDP frame form its header, most significant byte first: source port at byte positions 0-1, destination port at 2-3, length at 4-5, checksum at 6-7. The checksum is discarded. `src_port_o` and `dst_port_o` show the captured ports.
- R4: `pay_len_o` equals the header length field minus 8, modulo 2^16. For example, 0x000B gives 3, 0x000D gives 5 and 0xFFFF gives 0xFFF7.
- R5: `hdr_ok_o` is 1 from the cycle after the eighth header byte is accepted through the cycle that shows the last payload byte. It is 0 in the following cycle and at all other times.
- R6: Each accepted byte after the header appears on `pay_byte_o` with `pay_vld_o` = 1 one cycle later. Whenever `pay_vld_o` is 0, `pay_byte_o` is 0x00.
- R7: `udp_sof_o` is 1 for exactly one cycle, together with the first payload byte. The port, length and source-address outputs do not change while the payload of that datagram is delivered.
- R8: `pay_last_o` is 1 in the same cycle that carries the payload byte which arrived with `ip_last_i`, and at no other time.
- R9: In the cycle after a frame's last byte is shown, `pay_vld_o` and `pay_last_o` are 0 and `pay_byte_o` is 0x00.
- R10: The protocol number and source address are sampled only in the cycle where a frame opens, that is, when the parser is idle and both `ip_sof_i` and `ip_hdr_ok_i` are 1. For UDP frames the sampled address appears on `src_ip_o`. Later changes to these inputs within the frame have no effect.
- R11: A new frame is accepted in the cycle right after the last byte of the previous frame, whether that frame was UDP or rejected, and whether or not `ip_sof_i` stayed high in between.
- R12: A UDP frame whose last byte is at or before header byte position 7 is dropped. It produces no start pulse, no `hdr_ok_o` and no payload output.
- R13: Only cycles with `ip_vld_i` = 1 advance through the header. `ip_last_i` without valid is ignored. The header byte counter never exceeds 8, so payload bytes never alter the header outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ip_sof_i | input | 1 | IP layer frame start flag |
| ip_hdr_ok_i | input | 1 | IP header fields are valid |
| ip_proto_i | input | 8 | IP protocol number |
| ip_src_i | input | 32 | IP source address |
| ip_byte_i | input | 8 | IP payload byte |
| ip_vld_i | input | 1 | IP payload byte valid |
| ip_last_i | input | 1 | IP payload byte is the final one |
| udp_sof_o | output | 1 | Pulse with the first UDP payload byte |
| hdr_ok_o | output | 1 | UDP header captured and valid |
| src_ip_o | output | 32 | Source IP address of the datagram |
| src_port_o | output | 16 | UDP source port |
| dst_port_o | output | 16 | UDP destination port |
| pay_len_o | output | 16 | UDP payload length in bytes |
| pay_byte_o | output | 8 | Payload byte |
| pay_vld_o | output | 1 | Payload byte valid |
| pay_last_o | output | 1 | Final payload byte |

## Verification
Two functions can fall in the same cycle: closing one frame and opening the next. The edge that shows the final payload byte also returns the parser to idle. If `ip_sof_i` is still high, the following cycle immediately samples a new protocol and source address. The bench provokes this by chaining UDP and non-UDP frames with no idle cycles between them and the start flag held high. In the opening cycle of each new frame, it checks that the payload outputs have cleared, that `hdr_ok_o` has dropped, and that the new frame's header and payload still come out correctly. Randomized valid gaps, truncated headers and garbage on the IP header inputs after the opening cycle are mixed into the same stream.

// File: rtl/udp_rx_pkg.sv
package udp_rx_pkg;

    localparam int BYTE_W        = 8;
    localparam int PORT_W        = 16;
    localparam int ADDR_W        = 32;
    localparam int UDP_HDR_BYTES = 8;
    localparam int HDR_IDX_W     = $clog2(UDP_HDR_BYTES);
    localparam int HDR_CNT_W     = $clog2(UDP_HDR_BYTES + 1);

    // header byte positions the capture logic decodes
    localparam int POS_SPORT = 0;
    localparam int POS_DPORT = 2;
    localparam int POS_LEN   = 4;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_UDP,
        RX_SKIP
    } rx_state_e;

    typedef struct packed {
        logic                 open_udp;
        logic                 hdr_we;
        logic [HDR_IDX_W-1:0] idx;
        logic                 hdr_done;
        logic                 pay_beat;
    } rx_ctl_t;

    function automatic logic [PORT_W-1:0] payload_len(input logic [PORT_W-1:0] total);
        return total - PORT_W'(UDP_HDR_BYTES);
    endfunction

endpackage

// File: rtl/udp_rx_ctrl.sv
module udp_rx_ctrl
    import udp_rx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PROTO_UDP = 8'h11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ip_sof_i,
    input  logic              ip_hdr_ok_i,
    input  logic [BYTE_W-1:0] ip_proto_i,
    input  logic              ip_vld_i,
    input  logic              ip_last_i,
    output rx_ctl_t           ctl_o
);

    localparam logic [HDR_CNT_W-1:0] CNT_FULL = HDR_CNT_W'(UDP_HDR_BYTES);
    localparam logic [HDR_CNT_W-1:0] CNT_LAST = HDR_CNT_W'(UDP_HDR_BYTES - 1);

    rx_state_e            st_q;
    logic [HDR_CNT_W-1:0] cnt_q;

    logic                 open_w;
    logic                 proto_hit;
    logic                 is_udp;
    logic                 in_frame;
    logic                 beat;
    logic [HDR_CNT_W-1:0] pos;

    always_comb begin
        open_w    = (st_q == RX_IDLE) && ip_sof_i && ip_hdr_ok_i;
        proto_hit = (ip_proto_i == PROTO_UDP);
        is_udp    = open_w ? proto_hit : (st_q == RX_UDP);
        in_frame  = open_w || (st_q != RX_IDLE);
        pos       = open_w ? '0 : cnt_q;
        beat      = in_frame && ip_vld_i;

        ctl_o.open_udp = open_w && proto_hit;
        ctl_o.hdr_we   = is_udp && beat && (pos < CNT_FULL);
        ctl_o.idx      = pos[HDR_IDX_W-1:0];
        ctl_o.hdr_done = is_udp && beat && (pos == CNT_LAST) && !ip_last_i;
        ctl_o.pay_beat = is_udp && beat && (pos == CNT_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
        end else if (beat && ip_last_i) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
        end else if (open_w) begin
            st_q  <= proto_hit ? RX_UDP : RX_SKIP;
            cnt_q <= beat ? HDR_CNT_W'(1) : '0;
        end else if (beat && (cnt_q < CNT_FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R13
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL);

    // R12
    idle_cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_IDLE) |-> (cnt_q == '0));

endmodule

// File: rtl/udp_rx_hdr_cap.sv
module udp_rx_hdr_cap
    import udp_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_ctl_t           ctl_i,
    input  logic [BYTE_W-1:0] ip_byte_i,
    input  logic [ADDR_W-1:0] ip_src_i,
    input  logic              pay_last_q_i,
    output logic              hdr_ok_o,
    output logic [ADDR_W-1:0] src_ip_o,
    output logic [PORT_W-1:0] src_port_o,
    output logic [PORT_W-1:0] dst_port_o,
    output logic [PORT_W-1:0] pay_len_o
);

    localparam int N_PORTS = 2;

    logic [N_PORTS-1:0][PORT_W-1:0] port_q;
    logic [BYTE_W-1:0]              len_hi_q;

    genvar g;
    generate
        for (g = 0; g < N_PORTS; g++) begin : g_port
            localparam int BASE = (g == 0) ? POS_SPORT : POS_DPORT;
            always_ff @(posedge clk) begin
                if (rst) begin
                    port_q[g] <= '0;
                end else if (ctl_i.hdr_we) begin
                    if (ctl_i.idx == HDR_IDX_W'(BASE))
                        port_q[g][PORT_W-1:BYTE_W] <= ip_byte_i;
                    else if (ctl_i.idx == HDR_IDX_W'(BASE + 1))
                        port_q[g][BYTE_W-1:0] <= ip_byte_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            len_hi_q  <= '0;
            pay_len_o <= '0;
        end else if (ctl_i.hdr_we) begin
            if (ctl_i.idx == HDR_IDX_W'(POS_LEN))
                len_hi_q <= ip_byte_i;
            else if (ctl_i.idx == HDR_IDX_W'(POS_LEN + 1))
                pay_len_o <= payload_len({len_hi_q, ip_byte_i});
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            src_ip_o <= '0;
        else if (ctl_i.open_udp)
            src_ip_o <= ip_src_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hdr_ok_o <= 1'b0;
        else if (ctl_i.hdr_done)
            hdr_ok_o <= 1'b1;
        else if (pay_last_q_i)
            hdr_ok_o <= 1'b0;
    end

    assign src_port_o = port_q[0];
    assign dst_port_o = port_q[1];

    // R13
    hdr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_ok_o && !ctl_i.hdr_done) |=> ($stable(src_port_o) && $stable(dst_port_o)));

endmodule

// File: rtl/udp_rx_pay_out.sv
module udp_rx_pay_out
    import udp_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_ctl_t           ctl_i,
    input  logic [BYTE_W-1:0] ip_byte_i,
    input  logic              ip_last_i,
    output logic              udp_sof_o,
    output logic [BYTE_W-1:0] pay_byte_o,
    output logic              pay_vld_o,
    output logic              pay_last_o
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (ctl_i.hdr_done)
            armed_q <= 1'b1;
        else if (ctl_i.pay_beat)
            armed_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            udp_sof_o  <= 1'b0;
            pay_byte_o <= '0;
            pay_vld_o  <= 1'b0;
            pay_last_o <= 1'b0;
        end else begin
            udp_sof_o  <= ctl_i.pay_beat && armed_q;
            pay_byte_o <= ctl_i.pay_beat ? ip_byte_i : '0;
            pay_vld_o  <= ctl_i.pay_beat;
            pay_last_o <= ctl_i.pay_beat && ip_last_i;
        end
    end

    // R7
    one_sof_chk: assert property (@(posedge clk) disable iff (rst)
        udp_sof_o |=> !udp_sof_o);

endmodule

// File: rtl/udp_hdr_rx.sv
module udp_hdr_rx
    import udp_rx_pkg::*;
#(
    parameter logic [7:0] PROTO_UDP = 8'h11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ip_sof_i,
    input  logic        ip_hdr_ok_i,
    input  logic [7:0]  ip_proto_i,
    input  logic [31:0] ip_src_i,
    input  logic [7:0]  ip_byte_i,
    input  logic        ip_vld_i,
    input  logic        ip_last_i,
    output logic        udp_sof_o,
    output logic        hdr_ok_o,
    output logic [31:0] src_ip_o,
    output logic [15:0] src_port_o,
    output logic [15:0] dst_port_o,
    output logic [15:0] pay_len_o,
    output logic [7:0]  pay_byte_o,
    output logic        pay_vld_o,
    output logic        pay_last_o
);

    rx_ctl_t ctl;

    udp_rx_ctrl #(.PROTO_UDP(PROTO_UDP)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .ip_sof_i    (ip_sof_i),
        .ip_hdr_ok_i (ip_hdr_ok_i),
        .ip_proto_i  (ip_proto_i),
        .ip_vld_i    (ip_vld_i),
        .ip_last_i   (ip_last_i),
        .ctl_o       (ctl)
    );

    udp_rx_hdr_cap hdr_i (
        .clk          (clk),
        .rst          (rst),
        .ctl_i        (ctl),
        .ip_byte_i    (ip_byte_i),
        .ip_src_i     (ip_src_i),
        .pay_last_q_i (pay_last_o),
        .hdr_ok_o     (hdr_ok_o),
        .src_ip_o     (src_ip_o),
        .src_port_o   (src_port_o),
        .dst_port_o   (dst_port_o),
        .pay_len_o    (pay_len_o)
    );

    udp_rx_pay_out pay_i (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .ip_byte_i  (ip_byte_i),
        .ip_last_i  (ip_last_i),
        .udp_sof_o  (udp_sof_o),
        .pay_byte_o (pay_byte_o),
        .pay_vld_o  (pay_vld_o),
        .pay_last_o (pay_last_o)
    );

    // R8
    last_has_vld_chk: assert property (@(posedge clk) disable iff (rst)
        pay_last_o |-> pay_vld_o);

    // R7
    sof_with_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        udp_sof_o |-> (pay_vld_o && hdr_ok_o));

    // R5
    vld_needs_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        pay_vld_o |-> hdr_ok_o);

    // R5
    hdr_drop_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        pay_last_o |=> !hdr_ok_o);

    // R6
    idle_byte_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pay_vld_o |-> (pay_byte_o == 8'h00));

    // R7
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pay_vld_o && !udp_sof_o) |-> ($stable(src_port_o) && $stable(dst_port_o)
                                      && $stable(pay_len_o) && $stable(src_ip_o)));

endmodule

// File: tb/udp_hdr_rx_tb_top.sv
module udp_hdr_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ip_sof = 1'b0;
    logic        ip_hok = 1'b0;
    logic [7:0]  ip_proto = 8'h00;
    logic [31:0] ip_src = 32'h0;
    logic [7:0]  ip_byte = 8'h00;
    logic        ip_vld = 1'b0;
    logic        ip_last = 1'b0;

    logic        udp_sof, hdr_ok, pay_vld, pay_last;
    logic [31:0] src_ip;
    logic [15:0] src_port, dst_port, pay_len;
    logic [7:0]  pay_byte;

    int vecs = 0;
    int errs = 0;

    logic [15:0] e_sp = 16'h0, e_dp = 16'h0, e_len = 16'h0;
    logic [31:0] e_sip = 32'h0;
    bit          known = 1'b1;

    always #10 clk = ~clk;

    udp_hdr_rx dut_i (
        .clk(clk), .rst(rst),
        .ip_sof_i(ip_sof), .ip_hdr_ok_i(ip_hok), .ip_proto_i(ip_proto),
        .ip_src_i(ip_src), .ip_byte_i(ip_byte), .ip_vld_i(ip_vld), .ip_last_i(ip_last),
        .udp_sof_o(udp_sof), .hdr_ok_o(hdr_ok), .src_ip_o(src_ip),
        .src_port_o(src_port), .dst_port_o(dst_port), .pay_len_o(pay_len),
        .pay_byte_o(pay_byte), .pay_vld_o(pay_vld), .pay_last_o(pay_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] exp_len(input logic [15:0] f);
        return f - 16'd8;
    endfunction

    task automatic chk_fields_prev(input string tag);
        chk({tag, " src_port held"}, 32'(src_port), 32'(e_sp));
        chk({tag, " dst_port held"}, 32'(dst_port), 32'(e_dp));
        chk({tag, " pay_len held"}, 32'(pay_len), 32'(e_len));
        chk({tag, " src_ip held"}, src_ip, e_sip);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            ip_sof = 1'b0; ip_hok = 1'b0; ip_vld = 1'b0;
            ip_last = 1'($urandom); ip_byte = 8'($urandom);
            cyc();
            chk("R9 idle pay_vld", 32'(pay_vld), 32'd0);
            chk("R9 idle pay_byte", 32'(pay_byte), 32'd0);
            chk("R8 idle pay_last", 32'(pay_last), 32'd0);
            chk("R5 idle hdr_ok", 32'(hdr_ok), 32'd0);
        end
    endtask

    // cut > 0 ends the frame after cut bytes (truncated header)
    task automatic run_frame(input logic [7:0] proto, input logic [31:0] sip,
                             input logic [15:0] sp, input logic [15:0] dp,
                             input logic [15:0] lenf, input int npay, input int cut,
                             input int pre, input bit gaps);
        logic [7:0] fb [0:63];
        bit udp;
        bit full;
        int total;
        string tv;
        udp   = (proto == 8'h11);
        total = (cut > 0) ? cut : 8 + npay;
        full  = udp && (total > 8);
        tv    = udp ? "R12" : "R2";
        fb[0] = sp[15:8];   fb[1] = sp[7:0];
        fb[2] = dp[15:8];   fb[3] = dp[7:0];
        fb[4] = lenf[15:8]; fb[5] = lenf[7:0];
        fb[6] = 8'($urandom); fb[7] = 8'($urandom);
        for (int k = 8; k < 64; k++) fb[k] = 8'($urandom);

        // opening cycle (R10, R11)
        ip_sof = 1'b1; ip_hok = 1'b1; ip_proto = proto; ip_src = sip;
        ip_vld = 1'b0; ip_last = 1'b0; ip_byte = 8'($urandom);
        cyc();
        chk("R9 open pay_vld", 32'(pay_vld), 32'd0);
        chk("R9 open pay_byte", 32'(pay_byte), 32'd0);
        chk("R9 open pay_last", 32'(pay_last), 32'd0);
        chk("R11 open udp_sof", 32'(udp_sof), 32'd0);
        chk("R5 open hdr_ok", 32'(hdr_ok), 32'd0);
        // garbage on sampled-once inputs (R10)
        ip_proto = (proto == 8'h11) ? 8'h06 : 8'h11;
        ip_src   = $urandom;
        for (int p = 1; p < pre; p++) begin
            ip_vld = 1'b0;
            cyc();
            chk("R13 pre pay_vld", 32'(pay_vld), 32'd0);
        end
        for (int i = 0; i < total; i++) begin
            if (gaps && i > 0 && ($urandom % 3 == 0)) begin
                ip_vld = 1'b0; ip_last = 1'($urandom); ip_byte = 8'($urandom);
                cyc();
                chk("R13 gap pay_vld", 32'(pay_vld), 32'd0);
                chk("R6 gap pay_byte", 32'(pay_byte), 32'd0);
                chk("R5 gap hdr_ok", 32'(hdr_ok), (full && i >= 8) ? 32'd1 : 32'd0);
            end
            ip_vld = 1'b1; ip_byte = fb[i]; ip_last = (i == total - 1);
            cyc();
            if (full && i >= 8) begin
                chk("R6 pay_vld", 32'(pay_vld), 32'd1);
                chk("R6 pay_byte", 32'(pay_byte), 32'(fb[i]));
                chk("R8 pay_last", 32'(pay_last), (i == total - 1) ? 32'd1 : 32'd0);
                chk("R7 udp_sof", 32'(udp_sof), (i == 8) ? 32'd1 : 32'd0);
                chk("R5 hdr_ok payload", 32'(hdr_ok), 32'd1);
                chk("R3 src_port", 32'(src_port), 32'(sp));
                chk("R3 dst_port", 32'(dst_port), 32'(dp));
                chk("R4 pay_len", 32'(pay_len), 32'(exp_len(lenf)));
                chk("R10 src_ip", src_ip, sip);
            end else begin
                chk({tv, " pay_vld low"}, 32'(pay_vld), 32'd0);
                chk({tv, " pay_last low"}, 32'(pay_last), 32'd0);
                chk({tv, " udp_sof low"}, 32'(udp_sof), 32'd0);
                chk("R5 hdr_ok header", 32'(hdr_ok), (full && i == 7) ? 32'd1 : 32'd0);
                if (!udp && known) chk_fields_prev("R2");
            end
        end
        ip_vld = 1'b0; ip_last = 1'b0;
        if (full) begin
            e_sp = sp; e_dp = dp; e_len = exp_len(lenf); e_sip = sip; known = 1'b1;
        end else if (udp) begin
            known = 1'b0;
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc();
        // R1
        chk("R1 udp_sof", 32'(udp_sof), 32'd0);
        chk("R1 hdr_ok", 32'(hdr_ok), 32'd0);
        chk("R1 pay_vld", 32'(pay_vld), 32'd0);
        chk("R1 pay_last", 32'(pay_last), 32'd0);
        chk("R1 pay_byte", 32'(pay_byte), 32'd0);
        chk("R1 src_port", 32'(src_port), 32'd0);
        chk("R1 dst_port", 32'(dst_port), 32'd0);
        chk("R1 pay_len", 32'(pay_len), 32'd0);
        chk("R1 src_ip", src_ip, 32'd0);

        // directed: two datagrams then a rejected frame then UDP, back to back (R11)
        run_frame(8'h11, 32'hc0a80501, 16'h1498, 16'h8724, 16'h000b, 3, 0, 3, 1'b0);
        run_frame(8'h11, 32'hc0a80501, 16'h7623, 16'h0365, 16'h000d, 5, 0, 1, 1'b0);
        run_frame(8'h12, 32'h0a000001, 16'h7623, 16'h0365, 16'h000d, 5, 0, 2, 1'b0);
        run_frame(8'h11, 32'hc0a80502, 16'h1498, 16'h8724, 16'h000b, 3, 0, 1, 1'b0);
        idle(2);
        // R12: truncated headers
        run_frame(8'h11, 32'h01020304, 16'haaaa, 16'hbbbb, 16'h0009, 0, 8, 1, 1'b0);
        run_frame(8'h11, 32'h05060708, 16'hcccc, 16'hdddd, 16'h0009, 0, 4, 1, 1'b1);
        // R4 wrap, R13 gaps
        run_frame(8'h11, 32'hdeadbeef, 16'h0001, 16'hffff, 16'hffff, 2, 0, 1, 1'b1);
        run_frame(8'h11, 32'h11223344, 16'h0035, 16'h0400, 16'h0009, 1, 0, 2, 1'b1);
        idle(1);

        for (int f = 0; f < 60; f++) begin
            logic [7:0] pr;
            int np;
            int ct;
            pr = ($urandom % 10 < 7) ? 8'h11 : 8'($urandom);
            if (pr == 8'h11 && f % 7 == 3) pr = 8'h12;
            np = 1 + int'($urandom % 20);
            ct = ($urandom % 10 == 0) ? 1 + int'($urandom % 8) : 0;
            run_frame(pr, $urandom, 16'($urandom), 16'($urandom), 16'(np + 8), np, ct,
                      1 + int'($urandom % 3), 1'($urandom));
            idle(int'($urandom % 3));
        end
        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule